// File: doc/BRIEF.md
# Multicart Program Bank Translator

This block sits between a CPU address bus and the program ROM and work RAM of a multi-game cartridge. An inner bank-switching mapper supplies one 6-bit 8 KB bank number for each of the four 8 KB slots at 0x8000, 0xA000, 0xC000 and 0xE000. Outer control fields pick a game block and a banking mode. The translator merges the two and produces a physical ROM bank for the slot that the CPU is addressing. The mode decides how many of the low bank bits still come from the inner mapper. Three modes keep inner 8 KB banking at 64, 32 or 16 banks. A fourth maps one 16 KB bank twice, and a fifth maps one 32 KB bank.

The block holds two extra 8 KB slot registers. It fills them by taking over the inner mapper's bank-data port at 0x8001 when the override is enabled and the inner command selects one of them. When the override is on, these registers replace the two upper slots in the inner-banking modes. All other writes in 0x8000–0xFFFF are forwarded to the inner mapper. On the RAM-pattern board variant, the command values 0x46 and 0x47 written to 0x8000 are exchanged before they are forwarded. The work-RAM window at 0x6000–0x7FFF takes its page from the inner mapper's RAM control bits. Address translation is combinational. The only state is the two extra registers and a copy of the last legal slot table.

Top module: `prgx_bank_xlate`

## Requirements
- R1: The outer block is a 10-bit value. Bit 7 is `ob_hi0`, bit 8 is `ob_hi1`, and bit 9 is `ob_hi2`, which is used only when CHR_RAM_VARIANT=1 and is treated as 0 otherwise. Bits 6:5 are `ob_grp[6:5]`. All other bits are zero.
- R2: With `ob_mode`=0, the bank of every slot is (block << 1) OR inner bank bits 5:0.
- R3: With `ob_mode`=1, the bank is ((high block OR `ob_grp` AND 0x70) << 1) OR inner bits 4:0. With `ob_mode`=2, it is the same with mask 0x78 and inner bits 3:0. The high block is the value of R1 with bits 6:5 cleared.
- R4: With `ob_mode`=3, let B16 = block OR `ob_grp[4:0]`. Slots 0 and 2 give {B16,0}, and slots 1 and 3 give {B16,1}.
- R5: With `ob_mode`=4, slot k (k = CPU address bits 14:13) gives {B16[9:1], k}.
- R6: In modes 0–2 with `ob_xslot_en`=1, slot 2 gives extra register A and slot 3 gives extra register B. In modes 3 and 4 the extra registers have no effect.
- R7: A write to exactly 0x8001 while `ob_xslot_en`=1 and `cmd_ext`=1 is not forwarded (`inner_wr_en`=0). If `cmd_tgt`=0 the data is stored in extra register A on that clock, and if `cmd_tgt`=1 it is stored in extra register B.
- R8: Any other CPU write with address bit 15 set is forwarded with `inner_wr_en`=1 and leaves both extra registers unchanged.
- R9: With CHR_RAM_VARIANT=1, a write of 0x46 to exactly 0x8000 is forwarded as 0x47, and 0x47 is forwarded as 0x46. All other data and addresses pass through unchanged.
- R10: For addresses 0x6000–0x7FFF, `wram_ce`=1, `prg_ce`=0, and `wram_addr` = {`ram_ctrl`, address bits 12:0}.
- R11: While `ob_mode` is 5, 6 or 7, the slot table stays at the table of the last legal-mode clock, even if the other outer fields change. If no legal-mode clock has occurred since reset, it is all zeros.
- R12: After reset both extra registers read 0xFF.
- R13: `prg_ce` equals address bit 15. `prg_addr` = {`prg_bank`, address bits 12:0}, where `prg_bank` is the bank of slot (address bits 14:13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| ob_mode | input | 3 | Outer banking mode |
| ob_hi0 | input | 1 | Outer block bit 7 |
| ob_hi1 | input | 1 | Outer block bit 8 |
| ob_hi2 | input | 1 | Outer block bit 9 (RAM-pattern variant only) |
| ob_grp | input | 7 | Block bits 6:5 plus the 16 KB bank field and the mode masks |
| ob_xslot_en | input | 1 | Enables the extra-slot override and the port takeover |
| cmd_ext | input | 1 | Inner command flag that selects the extra registers |
| cmd_tgt | input | 2 | Inner command target index |
| inner_banks | input | 24 | Four 6-bit inner slot banks, slot 0 in the low bits |
| ram_ctrl | input | WRAM_PAGE_W | Inner work-RAM control page bits |
| prg_bank | output | BANK_W | 8 KB bank of the addressed slot |
| prg_addr | output | BANK_W+13 | Physical ROM byte address |
| prg_ce | output | 1 | ROM window selected |
| wram_ce | output | 1 | Work-RAM window selected |
| wram_addr | output | WRAM_PAGE_W+13 | Physical work-RAM byte address |
| inner_wr_en | output | 1 | Forwarded write strobe to the inner mapper |
| inner_wr_data | output | 8 | Forwarded write data, after the variant swap |

## Verification
The properties assume that the outer fields, the inner command bits and the inner banks change only between clock edges and hold steady while a write strobe is high. They also assume that `cpu_wr` is a clean single-cycle strobe. The stability property for illegal modes relies on the slot table being sampled once per clock, so it compares clock-to-clock and ignores glitches between edges. The directed stimulus changes every input just after a falling edge, keeps each write to one cycle, and checks combinational outputs one nanosecond later. Write results are checked only after the rising edge that captures them.

// File: rtl/prgx_pkg.sv
package prgx_pkg;
   localparam int IB_W = 6;   // inner 8 KB bank number width
   localparam int XV_W = 8;   // extra slot register width
   localparam int NSLOT = 4;  // 8 KB slots in 0x8000-0xFFFF
   localparam int NX = 2;     // extra slot registers

   typedef enum logic [2:0] {
      M_INNER64  = 3'd0,
      M_INNER32  = 3'd1,
      M_INNER16  = 3'd2,
      M_MIRROR16 = 3'd3,
      M_SPAN32   = 3'd4
   } mode_e;
endpackage

// File: rtl/prgx_slot_map.sv
module prgx_slot_map
   import prgx_pkg::*;
#(
   parameter int SLOT   = 0,
   parameter int BANK_W = 11
) (
   input  logic [2:0]        mode,
   input  logic [2:0]        hi_bits,
   input  logic [6:0]        grp,
   input  logic [IB_W-1:0]   inner,
   input  logic              xslot_en,
   input  logic [XV_W-1:0]   xval,
   output logic [BANK_W-1:0] bank
);
   localparam logic [1:0] SID = SLOT[1:0];

   logic [9:0]  hib, blk, b16;
   logic [10:0] b;

   assign hib = {hi_bits, 7'd0};
   assign blk = hib | {3'd0, grp[6:5], 5'd0};
   assign b16 = blk | {5'd0, grp[4:0]};

   always_comb begin
      case (mode)
         M_INNER64:  b = {blk, 1'b0} | {5'd0, inner[5:0]};
         M_INNER32:  b = {hib | {3'd0, grp[6:4], 4'd0}, 1'b0} | {6'd0, inner[4:0]};
         M_INNER16:  b = {hib | {3'd0, grp[6:3], 3'd0}, 1'b0} | {7'd0, inner[3:0]};
         M_MIRROR16: b = {b16, SID[0]};
         M_SPAN32:   b = {b16[9:1], SID};
         default:    b = '0;
      endcase
      if (SID[1] && xslot_en && (mode <= M_INNER16))
         b = {3'd0, xval};
   end

   assign bank = BANK_W'(b);
endmodule

// File: rtl/prgx_extra_cap.sv
module prgx_extra_cap
   import prgx_pkg::*;
#(
   parameter bit CHR_RAM_VARIANT = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_wr,
   input  logic [15:0]         cpu_addr,
   input  logic [7:0]          cpu_wdata,
   input  logic                xslot_en,
   input  logic                cmd_ext,
   input  logic [1:0]          cmd_tgt,
   output logic [NX*XV_W-1:0]  xvals,
   output logic                fwd_en,
   output logic [7:0]          fwd_data
);
   logic take;

   assign take   = cpu_wr && (cpu_addr == 16'h8001) && xslot_en && cmd_ext;
   assign fwd_en = cpu_wr && cpu_addr[15] && !take;

   for (genvar k = 0; k < NX; k++) begin : g_xreg
      always_ff @(posedge clk) begin
         if (!rst_n)
            xvals[k*XV_W +: XV_W] <= '1;
         else if (take && (cmd_tgt == 2'(k)))
            xvals[k*XV_W +: XV_W] <= cpu_wdata;
      end
   end

   if (CHR_RAM_VARIANT) begin : g_swap
      always_comb begin
         fwd_data = cpu_wdata;
         if (cpu_addr == 16'h8000 && cpu_wdata[7:1] == 7'h23)
            fwd_data = {cpu_wdata[7:1], ~cpu_wdata[0]};
      end
   end else begin : g_plain
      assign fwd_data = cpu_wdata;
   end
endmodule

// File: rtl/prgx_hold.sv
module prgx_hold #(
   parameter int W = 44
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         legal,
   input  logic [W-1:0] live,
   output logic [W-1:0] table_out
);
   logic [W-1:0] held;

   always_ff @(posedge clk) begin
      if (!rst_n)     held <= '0;
      else if (legal) held <= live;
   end

   assign table_out = legal ? live : held;
endmodule

// File: rtl/prgx_bank_xlate.sv
module prgx_bank_xlate
   import prgx_pkg::*;
#(
   parameter bit CHR_RAM_VARIANT = 1'b1,
   parameter int BANK_W          = 11,
   parameter int WRAM_PAGE_W     = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [15:0]              cpu_addr,
   input  logic                     cpu_wr,
   input  logic [7:0]               cpu_wdata,
   input  logic [2:0]               ob_mode,
   input  logic                     ob_hi0,
   input  logic                     ob_hi1,
   input  logic                     ob_hi2,
   input  logic [6:0]               ob_grp,
   input  logic                     ob_xslot_en,
   input  logic                     cmd_ext,
   input  logic [1:0]               cmd_tgt,
   input  logic [4*6-1:0]           inner_banks,
   input  logic [WRAM_PAGE_W-1:0]   ram_ctrl,
   output logic [BANK_W-1:0]        prg_bank,
   output logic [BANK_W+12:0]       prg_addr,
   output logic                     prg_ce,
   output logic                     wram_ce,
   output logic [WRAM_PAGE_W+12:0]  wram_addr,
   output logic                     inner_wr_en,
   output logic [7:0]               inner_wr_data
);
   localparam int TBL_W = NSLOT * BANK_W;

   if (BANK_W < 11) begin : g_bad_bank_w
      $error("BANK_W must hold an 11-bit bank number");
   end
   if (WRAM_PAGE_W < 1 || WRAM_PAGE_W > 8) begin : g_bad_page_w
      $error("WRAM_PAGE_W out of range");
   end

   logic [2:0]           hi_bits;
   logic [NX*XV_W-1:0]   xvals;
   logic [TBL_W-1:0]     live_banks;
   logic [TBL_W-1:0]     slot_banks;
   logic                 mode_legal;
   logic [1:0]           slot_idx;

   if (CHR_RAM_VARIANT) begin : g_hi_ram
      assign hi_bits = {ob_hi2, ob_hi1, ob_hi0};
   end else begin : g_hi_rom
      assign hi_bits = {1'b0, ob_hi1, ob_hi0};
   end

   prgx_extra_cap #(.CHR_RAM_VARIANT(CHR_RAM_VARIANT)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_wr   (cpu_wr),
      .cpu_addr (cpu_addr),
      .cpu_wdata(cpu_wdata),
      .xslot_en (ob_xslot_en),
      .cmd_ext  (cmd_ext),
      .cmd_tgt  (cmd_tgt),
      .xvals    (xvals),
      .fwd_en   (inner_wr_en),
      .fwd_data (inner_wr_data)
   );

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      prgx_slot_map #(.SLOT(s), .BANK_W(BANK_W)) u_map (
         .mode    (ob_mode),
         .hi_bits (hi_bits),
         .grp     (ob_grp),
         .inner   (inner_banks[s*IB_W +: IB_W]),
         .xslot_en(ob_xslot_en),
         .xval    (xvals[(s%NX)*XV_W +: XV_W]),
         .bank    (live_banks[s*BANK_W +: BANK_W])
      );
   end

   assign mode_legal = (ob_mode <= 3'd4);

   prgx_hold #(.W(TBL_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .legal    (mode_legal),
      .live     (live_banks),
      .table_out(slot_banks)
   );

   assign slot_idx  = cpu_addr[14:13];
   assign prg_bank  = slot_banks[slot_idx*BANK_W +: BANK_W];
   assign prg_addr  = {prg_bank, cpu_addr[12:0]};
   assign prg_ce    = cpu_addr[15];
   assign wram_ce   = (cpu_addr[15:13] == 3'b011);
   assign wram_addr = {ram_ctrl, cpu_addr[12:0]};
endmodule

// File: rtl/prgx_bank_xlate_chk.sv
module prgx_bank_xlate_chk #(
   parameter bit CHR_RAM_VARIANT = 1'b1,
   parameter int BANK_W          = 11,
   parameter int WRAM_PAGE_W     = 2,
   parameter int TBL_W           = 44
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [15:0]             cpu_addr,
   input logic                    cpu_wr,
   input logic [7:0]              cpu_wdata,
   input logic [2:0]              ob_mode,
   input logic                    ob_xslot_en,
   input logic                    cmd_ext,
   input logic [WRAM_PAGE_W-1:0]  ram_ctrl,
   input logic [BANK_W-1:0]       prg_bank,
   input logic                    wram_ce,
   input logic [WRAM_PAGE_W+12:0] wram_addr,
   input logic                    inner_wr_en,
   input logic [7:0]              inner_wr_data,
   input logic [TBL_W-1:0]        slot_banks
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   p_mirror16_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_mode == 3'd3 && cpu_addr[15]) |-> (prg_bank[0] == cpu_addr[13]));

   p_span32_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ob_mode == 3'd4 && cpu_addr[15]) |-> (prg_bank[1:0] == cpu_addr[14:13]));

   p_takeover_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_addr == 16'h8001 && ob_xslot_en && cmd_ext) |-> !inner_wr_en);

   p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (CHR_RAM_VARIANT && cpu_wr && cpu_addr == 16'h8000 && cpu_wdata == 8'h46)
         |-> (inner_wr_data == 8'h47));

   p_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wram_ce |-> (wram_addr[13 +: WRAM_PAGE_W] == ram_ctrl));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && ob_mode > 3'd4) |-> (slot_banks == $past(slot_banks)));
endmodule

bind prgx_bank_xlate prgx_bank_xlate_chk #(
   .CHR_RAM_VARIANT(CHR_RAM_VARIANT),
   .BANK_W         (BANK_W),
   .WRAM_PAGE_W    (WRAM_PAGE_W),
   .TBL_W          (TBL_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_addr     (cpu_addr),
   .cpu_wr       (cpu_wr),
   .cpu_wdata    (cpu_wdata),
   .ob_mode      (ob_mode),
   .ob_xslot_en  (ob_xslot_en),
   .cmd_ext      (cmd_ext),
   .ram_ctrl     (ram_ctrl),
   .prg_bank     (prg_bank),
   .wram_ce      (wram_ce),
   .wram_addr    (wram_addr),
   .inner_wr_en  (inner_wr_en),
   .inner_wr_data(inner_wr_data),
   .slot_banks   (slot_banks)
);

// File: tb/sim_prgx_bank_xlate.sv
module sim_prgx_bank_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h8000;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [2:0]  ob_mode = 3'd5;
   logic        ob_hi0 = 1'b0, ob_hi1 = 1'b0, ob_hi2 = 1'b0;
   logic [6:0]  ob_grp = 7'd0;
   logic        ob_xslot_en = 1'b0;
   logic        cmd_ext = 1'b0;
   logic [1:0]  cmd_tgt = 2'd0;
   logic [23:0] inner_banks = '0;
   logic [1:0]  ram_ctrl = 2'd0;
   logic [10:0] prg_bank;
   logic [23:0] prg_addr;
   logic        prg_ce, wram_ce, inner_wr_en;
   logic [14:0] wram_addr;
   logic [7:0]  inner_wr_data;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   prgx_bank_xlate u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .ob_mode(ob_mode), .ob_hi0(ob_hi0), .ob_hi1(ob_hi1),
      .ob_hi2(ob_hi2), .ob_grp(ob_grp), .ob_xslot_en(ob_xslot_en),
      .cmd_ext(cmd_ext), .cmd_tgt(cmd_tgt), .inner_banks(inner_banks),
      .ram_ctrl(ram_ctrl), .prg_bank(prg_bank), .prg_addr(prg_addr),
      .prg_ce(prg_ce), .wram_ce(wram_ce), .wram_addr(wram_addr),
      .inner_wr_en(inner_wr_en), .inner_wr_data(inner_wr_data)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic bank_at(input logic [15:0] a, input logic [10:0] exp, input string tag);
      cpu_addr = a;
      #1;
      chk(tag, 32'(prg_bank), 32'(exp));
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                            input logic exp_fwd, input string tag);
      @(negedge clk);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      #1;
      chk(tag, 32'(inner_wr_en), 32'(exp_fwd));
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic t_reset_r12;
      // R11: no legal clock yet, illegal mode -> table all zeros
      bank_at(16'h8000, 11'h000, "R11 reset table");
      bank_at(16'hE000, 11'h000, "R11 reset table");
      @(negedge clk);
      ob_mode = 3'd0; ob_xslot_en = 1'b1;
      bank_at(16'hC000, 11'h0FF, "R12 extra A reset");
      bank_at(16'hE000, 11'h0FF, "R12 extra B reset");
      ob_xslot_en = 1'b0;
   endtask

   task automatic t_mode0_r2;
      ob_mode = 3'd0; ob_hi0 = 1; ob_hi1 = 1; ob_hi2 = 1; ob_grp = 7'h20;
      inner_banks = {6'd0, 6'd0, 6'd0, 6'h05};
      bank_at(16'h8000, 11'h745, "R1 R2 block merge");
      ob_grp = 7'h60; inner_banks = {6'h3F, 6'd0, 6'd0, 6'd0};
      bank_at(16'hE000, 11'h7FF, "R2 all ones");
      ob_hi2 = 0; ob_hi1 = 0;
      bank_at(16'hE000, 11'h1FF, "R1 hi bits cleared");
      ob_hi0 = 0;
   endtask

   task automatic t_mode12_r3;
      ob_mode = 3'd1; ob_grp = 7'h70; inner_banks = {6'd0, 6'd0, 6'h25, 6'd0};
      bank_at(16'hA000, 11'h0E5, "R3 mode1");
      ob_mode = 3'd2; ob_grp = 7'h78; inner_banks = {6'd0, 6'h2A, 6'd0, 6'd0};
      bank_at(16'hC000, 11'h0FA, "R3 mode2");
   endtask

   task automatic t_mode3_r4;
      ob_mode = 3'd3; ob_grp = 7'h45;
      bank_at(16'h8000, 11'h08A, "R4 slot0");
      bank_at(16'hA000, 11'h08B, "R4 slot1");
      bank_at(16'hC000, 11'h08A, "R4 slot2");
      bank_at(16'hE000, 11'h08B, "R4 slot3");
   endtask

   task automatic t_mode4_r5;
      ob_mode = 3'd4; ob_grp = 7'h47;
      for (int k = 0; k < 4; k++)
         bank_at(16'h8000 + 16'(k * 16'h2000), 11'h08C + 11'(k), "R5 span32");
   endtask

   task automatic t_extra_r7;
      ob_mode = 3'd0; ob_grp = 7'h00; ob_xslot_en = 1'b1; cmd_ext = 1'b1;
      inner_banks = {6'h11, 6'h22, 6'h03, 6'h00};
      cmd_tgt = 2'd0; cpu_write(16'h8001, 8'h12, 1'b0, "R7 takeover A");
      cmd_tgt = 2'd1; cpu_write(16'h8001, 8'h34, 1'b0, "R7 takeover B");
      bank_at(16'hC000, 11'h012, "R6 R7 slot2 extra");
      bank_at(16'hE000, 11'h034, "R6 R7 slot3 extra");
      bank_at(16'hA000, 11'h003, "R6 slot1 inner");
      ob_mode = 3'd3; ob_grp = 7'h45;
      bank_at(16'hC000, 11'h08A, "R6 mode3 ignores extra");
      ob_mode = 3'd0; ob_grp = 7'h00;
   endtask

   task automatic t_forward_r8;
      ob_xslot_en = 1'b0; cmd_tgt = 2'd0;
      cpu_write(16'h8001, 8'h77, 1'b1, "R8 forward no override");
      ob_xslot_en = 1'b1; cmd_ext = 1'b0;
      cpu_write(16'h8001, 8'h66, 1'b1, "R8 forward no cmd flag");
      cmd_ext = 1'b1;
      cpu_write(16'hA001, 8'h55, 1'b1, "R8 forward other addr");
      cpu_write(16'h5001, 8'h55, 1'b0, "R8 low addr not forwarded");
      bank_at(16'hC000, 11'h012, "R8 extra A unchanged");
      bank_at(16'hE000, 11'h034, "R8 extra B unchanged");
      ob_xslot_en = 1'b0; cmd_ext = 1'b0;
   endtask

   task automatic t_swap_r9;
      @(negedge clk);
      cpu_addr = 16'h8000; cpu_wr = 1'b1;
      cpu_wdata = 8'h46; #1; chk("R9 46->47", 32'(inner_wr_data), 32'h47);
      cpu_wdata = 8'h47; #1; chk("R9 47->46", 32'(inner_wr_data), 32'h46);
      cpu_wdata = 8'h48; #1; chk("R9 other data", 32'(inner_wr_data), 32'h48);
      cpu_addr = 16'h8001; cpu_wdata = 8'h46; #1;
      chk("R9 other addr", 32'(inner_wr_data), 32'h46);
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic t_wram_r10;
      ram_ctrl = 2'd3; cpu_addr = 16'h6000; #1;
      chk("R10 wram_ce", 32'(wram_ce), 32'd1);
      chk("R10 prg_ce off", 32'(prg_ce), 32'd0);
      chk("R10 page 3", 32'(wram_addr), 32'h6000);
      ram_ctrl = 2'd2; cpu_addr = 16'h7FFF; #1;
      chk("R10 page 2", 32'(wram_addr), 32'h5FFF);
      cpu_addr = 16'h8000; #1;
      chk("R10 wram_ce off", 32'(wram_ce), 32'd0);
   endtask

   task automatic t_addr_r13;
      @(negedge clk);
      ob_mode = 3'd4; ob_grp = 7'h47;
      cpu_addr = 16'hE123; #1;
      chk("R13 prg_ce", 32'(prg_ce), 32'd1);
      chk("R13 prg_addr", 32'(prg_addr), {8'd0, 11'h08F, 13'h0123});
   endtask

   task automatic t_hold_r11;
      @(negedge clk);
      ob_mode = 3'd4; ob_grp = 7'h47;
      @(negedge clk);
      ob_mode = 3'd5; ob_grp = 7'h00;
      bank_at(16'h8000, 11'h08C, "R11 hold slot0");
      bank_at(16'hE000, 11'h08F, "R11 hold slot3");
      @(negedge clk);
      ob_mode = 3'd7; ob_hi1 = 1'b1;
      bank_at(16'hA000, 11'h08D, "R11 hold after clock");
      ob_mode = 3'd0; ob_hi1 = 1'b0; inner_banks = '0;
      bank_at(16'hA000, 11'h000, "R11 legal resumes");
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_r12();
      t_mode0_r2();
      t_mode12_r3();
      t_mode3_r4();
      t_mode4_r5();
      t_extra_r7();
      t_forward_r8();
      t_swap_r9();
      t_wram_r10();
      t_addr_r13();
      t_hold_r11();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule